// File: doc/BRIEF.md
# Configurable Bit I/O Port

This block controls a small group of general-purpose pins, eight by default. Each pin is made an input or an output on its own by a direction register. An output latch drives the pins. A single modify command changes that latch with two masks, a set mask and a clear mask. A pin named in only the set mask goes to 1. A pin named in only the clear mask goes to 0. A pin named in both masks toggles. A pin named in neither mask keeps its value.

Input pins pass through a synchronizer before they are used. A test command stores a compare mask and a pattern. Four flags then report whether the masked pins agree with the pattern: all of them, any of them, none of them, or not all of them. A conditional sequencer can branch on these flags. Software drives the block through a write port carrying a command code and a data word. A read port selects one of several views of the pin state.

Top module: `bitio_port`

## Requirements
- R1: After reset, pin_oe and pin_out are all 0. The stored compare mask and pattern are 0, so flags reads 4'b0101.
- R2: A write with wr_sel=0 loads wr_data[NPINS-1:0] into the direction register (1 = output). pin_oe shows the new value from the clock edge that takes the write.
- R3: A write with wr_sel=1 uses wr_data[NPINS-1:0] as the set mask and wr_data[2*NPINS-1:NPINS] as the clear mask. Per pin, set only gives 1, clear only gives 0, both toggle the latch and neither keeps it. pin_out shows the result from the write edge onward.
- R4: Pins whose set and clear bits are both 0 keep their output latch value across a modify write.
- R5: rd_sel=1 returns the pin view. An output pin reads its latch value; an input pin reads its synchronized input.
- R6: pin_in reaches the pin view and the flags two rising edges after it changes, and not after one.
- R7: A write with wr_sel=2 stores wr_data[NPINS-1:0] as the compare mask and wr_data[2*NPINS-1:NPINS] as the pattern. The flags compare the pin view with the pattern over the masked bits. The flag bits are [0] all masked bits equal, [1] any masked bit equal, [2] all masked bits differ, [3] any masked bit differs.
- R8: Bits outside the compare mask have no effect on the flags. An empty mask gives flags 4'b0101.
- R9: rd_sel=0 returns the direction register, rd_sel=2 returns the output latch and rd_sel=3 returns 0.
- R10: A write with wr_sel=3 changes no register: pin_out, pin_oe and flags stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Command: 0 direction, 1 modify, 2 test, 3 none |
| wr_data | input | 2*NPINS | Command data (low half / high half) |
| rd_sel | input | 2 | Read view: 0 direction, 1 pins, 2 latch, 3 zero |
| rd_data | output | NPINS | Selected read view (combinational) |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enables (1 = pin driven) |
| flags | output | 4 | Pattern test flags |

## Verification
Register writes (direction, modify, test) show up at pin_oe, pin_out, rd_data and flags right after the edge that takes the write. The bench therefore drives each write on a falling edge and samples on the next falling edge. A change on pin_in needs two rising edges before the pin view and the flags follow it. The bench sets pin_in, checks at the falling edge after one rising edge that nothing has moved yet, and checks again after the second rising edge that the new value is there. In the table walk, every new pin_in value is held for three edges before any sample is taken.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
   typedef enum logic [1:0] {
      CMD_DIR  = 2'd0,
      CMD_MOD  = 2'd1,
      CMD_TEST = 2'd2,
      CMD_NONE = 2'd3
   } bitio_cmd_e;

   typedef enum logic [1:0] {
      RD_DIR   = 2'd0,
      RD_PINS  = 2'd1,
      RD_LATCH = 2'd2,
      RD_ZERO  = 2'd3
   } bitio_rd_e;

   localparam int FLG_ALL_EQ = 0;
   localparam int FLG_ANY_EQ = 1;
   localparam int FLG_ALL_NE = 2;
   localparam int FLG_ANY_NE = 3;
   localparam int FLG_W      = 4;
endpackage

// File: rtl/bitio_sync.sv
module bitio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bitio_regs.sv
module bitio_regs
   import bitio_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [NPINS-1:0] lo,
   input  logic [NPINS-1:0] hi,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] latch_q,
   output logic [NPINS-1:0] mask_q,
   output logic [NPINS-1:0] pat_q
);
   logic do_dir, do_mod, do_test;
   logic [NPINS-1:0] latch_d;

   assign do_dir  = wr_en && (wr_sel == CMD_DIR);
   assign do_mod  = wr_en && (wr_sel == CMD_MOD);
   assign do_test = wr_en && (wr_sel == CMD_TEST);

   for (genvar i = 0; i < NPINS; i++) begin : g_bit
      always_comb begin
         unique case ({lo[i], hi[i]})
            2'b10:   latch_d[i] = 1'b1;
            2'b01:   latch_d[i] = 1'b0;
            2'b11:   latch_d[i] = ~latch_q[i];
            default: latch_d[i] = latch_q[i];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q   <= '0;
         latch_q <= '0;
         mask_q  <= '0;
         pat_q   <= '0;
      end else begin
         if (do_dir)  dir_q   <= lo;
         if (do_mod)  latch_q <= latch_d;
         if (do_test) begin
            mask_q <= lo;
            pat_q  <= hi;
         end
      end
   end
endmodule

// File: rtl/bitio_match.sv
module bitio_match
   import bitio_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic [NPINS-1:0] view,
   input  logic [NPINS-1:0] mask,
   input  logic [NPINS-1:0] pat,
   output logic [FLG_W-1:0] flags
);
   logic [NPINS-1:0] eq_m, ne_m;

   assign ne_m = (view ^ pat) & mask;
   assign eq_m = ~(view ^ pat) & mask;

   assign flags[FLG_ALL_EQ] = (eq_m == mask);
   assign flags[FLG_ANY_EQ] = |eq_m;
   assign flags[FLG_ALL_NE] = (ne_m == mask);
   assign flags[FLG_ANY_NE] = |ne_m;
endmodule

// File: rtl/bitio_port.sv
module bitio_port
   import bitio_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [2*NPINS-1:0] wr_data,
   input  logic [1:0]         rd_sel,
   output logic [NPINS-1:0]   rd_data,
   input  logic [NPINS-1:0]   pin_in,
   output logic [NPINS-1:0]   pin_out,
   output logic [NPINS-1:0]   pin_oe,
   output logic [FLG_W-1:0]   flags
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("bitio_port: NPINS must be 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bitio_port: SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] in_s, dir_q, latch_q, mask_q, pat_q, view;

   bitio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_s)
   );

   bitio_regs #(.NPINS(NPINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .lo(wr_data[NPINS-1:0]), .hi(wr_data[2*NPINS-1:NPINS]),
      .dir_q(dir_q), .latch_q(latch_q), .mask_q(mask_q), .pat_q(pat_q)
   );

   assign view = (dir_q & latch_q) | (~dir_q & in_s);

   bitio_match #(.NPINS(NPINS)) u_match (
      .view(view), .mask(mask_q), .pat(pat_q), .flags(flags)
   );

   always_comb begin
      unique case (rd_sel)
         RD_DIR:   rd_data = dir_q;
         RD_PINS:  rd_data = view;
         RD_LATCH: rd_data = latch_q;
         default:  rd_data = '0;
      endcase
   end

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;
endmodule

// File: rtl/bitio_port_chk.sv
module bitio_port_chk #(
   parameter int NPINS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         wr_sel,
   input logic [2*NPINS-1:0] wr_data,
   input logic [NPINS-1:0]   pin_out,
   input logic [NPINS-1:0]   pin_oe,
   input logic [3:0]         flags
);
   logic [NPINS-1:0] set_m, clr_m;
   assign set_m = wr_data[NPINS-1:0];
   assign clr_m = wr_data[2*NPINS-1:NPINS];

   a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> pin_oe == $past(set_m));

   a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=>
         ((pin_out ^ $past(pin_out)) & $past(set_m & clr_m)) == $past(set_m & clr_m));

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=>
         ((pin_out ^ $past(pin_out)) & ~$past(set_m | clr_m)) == '0);

   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_sel == 2'd3) |=> ($stable(pin_out) && $stable(pin_oe)));

   a_r7_flags_consistent: assert property (@(posedge clk) disable iff (!rst_n)
      !(flags[0] && flags[3]) && !(flags[1] && flags[2]));
endmodule

bind bitio_port bitio_port_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .pin_out(pin_out), .pin_oe(pin_oe), .flags(flags)
);

// File: tb/sim_bitio_port.sv
module sim_bitio_port;
   localparam int N = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [1:0]     wr_sel = 2'd3;
   logic [2*N-1:0] wr_data = '0;
   logic [1:0]     rd_sel = 2'd0;
   logic [N-1:0]   rd_data, pin_in, pin_out, pin_oe;
   logic [3:0]     flags;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bitio_port #(.NPINS(N), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .flags(flags)
   );

   // kind 1: modify write, expect pin_out; kind 2: test write, expect flags
   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  pins;
      logic [15:0] data;
      logic [7:0]  exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{2'd1, 8'h00, 16'h000F, 8'h0F},
      '{2'd1, 8'h00, 16'h0300, 8'h0C},
      '{2'd1, 8'h00, 16'hF0F0, 8'hFC},
      '{2'd1, 8'h00, 16'h8081, 8'h7D},
      '{2'd1, 8'h00, 16'hFF00, 8'h00},
      '{2'd1, 8'h00, 16'hFFAA, 8'hAA},
      '{2'd2, 8'hA5, 16'hA5FF, 8'h03},
      '{2'd2, 8'hA5, 16'h5AFF, 8'h0C},
      '{2'd2, 8'hA5, 16'h050F, 8'h03},
      '{2'd2, 8'hA5, 16'h040F, 8'h0A},
      '{2'd2, 8'hA5, 16'h3C00, 8'h05},
      '{2'd2, 8'h00, 16'h8080, 8'h0C}
   };

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [2*N-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
   endtask

   task automatic settle(input logic [N-1:0] p);
      @(negedge clk);
      pin_in = p;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      pin_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", pin_oe, 8'h00);
      check("R1 pin_out", pin_out, 8'h00);
      check("R1 flags", {4'h0, flags}, 8'h05);

      // Table walk: R3/R4 modify, R7/R8 flags
      for (int i = 0; i < NV; i++) begin
         settle(VT[i].pins);
         wr(VT[i].kind, VT[i].data);
         if (VT[i].kind == 2'd1) check("R3/R4 modify table", pin_out, VT[i].exp);
         else                    check("R7/R8 flag table", {4'h0, flags}, VT[i].exp);
      end

      // R8: unmasked bits ignored (mask 0F, pattern 05; vary upper pins)
      wr(2'd2, 16'h050F);
      settle(8'h35);
      check("R8 unmasked change", {4'h0, flags}, 8'h03);
      settle(8'hC5);
      check("R8 unmasked change 2", {4'h0, flags}, 8'h03);

      // R2 direction
      wr(2'd0, 16'h00F0);
      check("R2 pin_oe", pin_oe, 8'hF0);
      rd_sel = 2'd0; #1;
      check("R9 rd dir", rd_data, 8'hF0);

      // R5 pin view: latch AA on outputs, inputs 0x5 low
      settle(8'h35);
      rd_sel = 2'd1; #1;
      check("R5 pin view", rd_data, 8'hA5);
      rd_sel = 2'd2; #1;
      check("R9 rd latch", rd_data, 8'hAA);
      rd_sel = 2'd3; #1;
      check("R9 rd zero", rd_data, 8'h00);

      // R6 synchronizer latency (inputs low nibble)
      rd_sel = 2'd1;
      @(negedge clk);
      pin_in = 8'h0A;
      @(negedge clk);
      check("R6 not after one edge", rd_data, 8'hA5);
      @(negedge clk);
      check("R6 after two edges", rd_data, 8'hAA);

      // R10 no-op command
      wr(2'd3, 16'hFFFF);
      check("R10 pin_out", pin_out, 8'hAA);
      check("R10 pin_oe", pin_oe, 8'hF0);
      check("R10 flags", {4'h0, flags}, 8'h0C);

      // R1 reset again after activity
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R1 re-reset pin_out", pin_out, 8'h00);
      check("R1 re-reset flags", {4'h0, flags}, 8'h05);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule